// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block turns a reference clock into a card clock running at the reference rate, half of it, a quarter of it or an eighth of it. Two select inputs choose the ratio. A run enable from the power sequencer starts or stops the output, and a stopped output sits low. Both the ratio and the run enable may change while the output is toggling.

No pulse is ever cut short. All divided waveforms come from one free-running counter, and they all fall together when that counter wraps. A new ratio or run state is committed only on the falling reference edge that follows a wrap. At that point the old waveform has just finished a full high phase and the new one is starting a full low phase.

The select and run inputs come from another clock domain. Each one passes through a synchronizer and then a stability filter, so a select that only flickers never reaches the output.

Top module: `card_clk_divider`

## Requirements
- R1: The select code sets the ratio. 2'b00 divides by 8, 2'b01 by 4 and 2'b11 by 2. A divided output is high for exactly half its period, which is ratio/2 reference cycles, and low for the other half.
- R2: Select 2'b10 passes the reference through undivided. Each high phase and each low phase lasts half a reference period.
- R3: A ratio change takes effect only where every divided waveform has just fallen. Each output phase during the change lasts no less than the shorter and no more than the longer of the old and new half-periods. Between two divided ratios, the phase after the change is exactly the new half-period.
- R4: While run is low, the output is held low. The last high phase before the stop has its full width.
- R5: Starting the output produces a full-width first high phase. No low phase after a start is shorter than the selected half-period.
- R6: A select value must stay unchanged through the synchronizer and for two further reference cycles before it is used. A select pulse of one reference cycle is ignored.
- R7: During synchronous reset the output is low. The held ratio becomes divide-by-8 with the output stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 2 | Ratio select, asynchronous (encoding in R1/R2) |
| run | input | 1 | Output enable from the sequencer, asynchronous |
| card_clk | output | 1 | Card clock |

## Verification
The bench uses the default parameters: a 3-bit phase counter, two synchronizer stages and a two-cycle hold. With these values a full wrap takes only 8 reference cycles. That makes it cheap to run every ordered pair of ratio changes and to run start/stop in both the divided and pass-through modes. The two-cycle hold also lets the bench show that a one-cycle select pulse is filtered out.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

  // Select encoding; the values are behaviour (non-binary ratio order).
  typedef enum logic [1:0] {
    SEL_DIV8 = 2'b00,
    SEL_DIV4 = 2'b01,
    SEL_THRU = 2'b10,
    SEL_DIV2 = 2'b11
  } ccd_sel_e;

  // log2 of the division ratio for a select code
  function automatic int unsigned ccd_ratio_log2(input ccd_sel_e s);
    case (s)
      SEL_DIV8: return 3;
      SEL_DIV4: return 2;
      SEL_DIV2: return 1;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/ccd_input_filter.sv
// Synchronizer plus stability filter for a slow control input.
module ccd_input_filter #(
  parameter int unsigned WIDTH       = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYCLES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int unsigned HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYCLES - 1);
  localparam logic [HOLD_W-1:0] HOLD_MAX  = HOLD_W'(HOLD_CYCLES);

  logic [SYNC_STAGES-1:0][WIDTH-1:0] chain;
  logic [WIDTH-1:0]  q;
  logic [WIDTH-1:0]  prev;
  logic [HOLD_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RESET_VAL;
    else     chain[0] <= din;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= RESET_VAL;
      else     chain[g] <= chain[g-1];
    end
  end

  assign q = chain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= RESET_VAL;
      hold <= '0;
      dout <= RESET_VAL;
    end else begin
      prev <= q;
      if (q != prev)            hold <= '0;
      else if (hold != HOLD_MAX) hold <= hold + 1'b1;
      if (q == prev && hold == HOLD_LAST) dout <= q;
    end
  end

  // R6: an accepted value was seen unchanged on consecutive samples
  if (HOLD_CYCLES >= 2) begin : g_chk
    p_accept_held_r6: assert property (@(posedge clk) disable iff (rst)
      (dout != $past(dout)) |-> ($past(q) == $past(q, 2)));
  end

endmodule

// File: rtl/ccd_phase_counter.sv
// Free-running counter whose bits are the divided waveforms.
module ccd_phase_counter #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             at_wrap
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // all waveform bits just fell together
  assign at_wrap = (cnt == '0);

endmodule

// File: rtl/ccd_commit_ctrl.sv
// Commits ratio and run changes on the falling reference edge after a wrap.
module ccd_commit_ctrl
  import ccd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     at_wrap,
  input  ccd_sel_e req_sel,
  input  logic     req_run,
  output ccd_sel_e cur_sel,
  output logic     cur_run
);
  always_ff @(negedge clk) begin
    if (rst) begin
      cur_sel <= SEL_DIV8;
      cur_run <= 1'b0;
    end else if (at_wrap) begin
      cur_sel <= req_sel;
      cur_run <= req_run;
    end
  end

  // R3: ratio only changes at the wrap point
  p_sel_commit_r3: assert property (@(negedge clk) disable iff (rst)
    (cur_sel != $past(cur_sel)) |-> $past(at_wrap));

  // R5: run only changes at the wrap point
  p_run_commit_r5: assert property (@(negedge clk) disable iff (rst)
    (cur_run != $past(cur_run)) |-> $past(at_wrap));

endmodule

// File: rtl/card_clk_divider.sv
module card_clk_divider
  import ccd_pkg::*;
#(
  parameter int unsigned CNT_W       = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       run,
  output logic       card_clk
);
  logic [1:0]       sel_f;
  logic             run_f;
  logic [CNT_W-1:0] cnt;
  logic             at_wrap;
  ccd_sel_e         cur_sel;
  logic             cur_run;
  logic             wave;

  ccd_input_filter #(
    .WIDTH(2), .SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(HOLD_CYCLES),
    .RESET_VAL(SEL_DIV8)
  ) u_sel_filt (
    .clk(clk), .rst(rst), .din(sel), .dout(sel_f)
  );

  ccd_input_filter #(
    .WIDTH(1), .SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(HOLD_CYCLES),
    .RESET_VAL(1'b0)
  ) u_run_filt (
    .clk(clk), .rst(rst), .din(run), .dout(run_f)
  );

  ccd_phase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt(cnt), .at_wrap(at_wrap)
  );

  ccd_commit_ctrl u_ctrl (
    .clk(clk), .rst(rst), .at_wrap(at_wrap),
    .req_sel(ccd_sel_e'(sel_f)), .req_run(run_f),
    .cur_sel(cur_sel), .cur_run(cur_run)
  );

  always_comb begin
    case (cur_sel)
      SEL_THRU: wave = clk;
      SEL_DIV2: wave = cnt[0];
      SEL_DIV4: wave = cnt[1];
      default:  wave = cnt[2];
    endcase
  end

  assign card_clk = cur_run & wave;

  // R1: a settled divide-by-2 output toggles on every reference rising edge
  p_div2_toggle_r1: assert property (@(posedge clk) disable iff (rst)
    (cur_run && cur_sel == SEL_DIV2 && $past(cur_run && cur_sel == SEL_DIV2))
      |-> (card_clk != $past(card_clk)));

endmodule

// File: tb/card_clk_divider_test.sv
module card_clk_divider_test;
  localparam int CLK_PERIOD = 10;
  localparam int LOG_MAX    = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       run = 1'b0;
  logic       card_clk;

  int checks = 0;
  int fails  = 0;

  card_clk_divider uut (
    .clk(clk), .rst(rst), .sel(sel), .run(run), .card_clk(card_clk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // phase log: width and level of each completed output phase
  longint ph_w  [LOG_MAX];
  bit     ph_hi [LOG_MAX];
  int     ph_n    = 0;
  bit     logging = 1'b0;
  longint last_t  = 0;

  always @(card_clk) begin
    if (logging && ph_n < LOG_MAX) begin
      ph_w[ph_n]  = longint'($time) - last_t;
      ph_hi[ph_n] = !card_clk;
      ph_n++;
    end
    last_t = longint'($time);
  end

  function automatic longint half_of(input logic [1:0] s);
    case (s)
      2'b00:   return 4 * CLK_PERIOD;
      2'b01:   return 2 * CLK_PERIOD;
      2'b11:   return CLK_PERIOD;
      default: return CLK_PERIOD / 2;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic log_start();
    ph_n = 0;
    logging = 1'b1;
  endtask

  // R7: output low in reset and after release while stopped; R4 parked low
  task automatic t_reset();
    rst = 1'b1; run = 1'b0; sel = 2'b00;
    cyc(6);
    chk(card_clk == 1'b0, "R7 reset output", card_clk, 0);
    rst = 1'b0;
    for (int i = 0; i < 30; i++) begin
      cyc(1);
      chk(card_clk == 1'b0, "R4 stopped after reset", card_clk, 0);
    end
  endtask

  // R1 / R2: steady ratio, every phase is the half-period
  task automatic t_steady(input logic [1:0] s, input string req);
    longint h = half_of(s);
    sel = s; run = 1'b1;
    cyc(40);
    log_start();
    cyc(64);
    logging = 1'b0;
    chk(ph_n >= 4, {req, " phase count"}, ph_n, 4);
    for (int i = 0; i < ph_n; i++)
      chk(ph_w[i] == h, {req, " phase width"}, ph_w[i], h);
  endtask

  // R3: change ratio while running
  task automatic t_switch(input logic [1:0] from_s, input logic [1:0] to_s);
    longint ho = half_of(from_s);
    longint hn = half_of(to_s);
    longint lo = (ho < hn) ? ho : hn;
    longint hi = (ho < hn) ? hn : ho;
    sel = from_s; run = 1'b1;
    cyc(40);
    log_start();
    sel = to_s;
    cyc(60);
    logging = 1'b0;
    for (int i = 0; i < ph_n; i++)
      chk(ph_w[i] >= lo && ph_w[i] <= hi, "R3 phase bounded during change", ph_w[i], lo);
    chk(ph_n > 0 && ph_w[ph_n-1] == hn, "R3 settles on new ratio", ph_w[ph_n-1], hn);
  endtask

  // R6: one-cycle select pulse ignored
  task automatic t_glitch();
    sel = 2'b01; run = 1'b1;
    cyc(40);
    log_start();
    sel = 2'b11;
    cyc(1);
    sel = 2'b01;
    cyc(60);
    logging = 1'b0;
    for (int i = 0; i < ph_n; i++)
      chk(ph_w[i] == half_of(2'b01), "R6 short select ignored", ph_w[i], half_of(2'b01));
  endtask

  // R4 / R5: stop and start
  task automatic t_run(input logic [1:0] s);
    longint h = half_of(s);
    sel = s; run = 1'b1;
    cyc(40);
    log_start();
    run = 1'b0;
    cyc(40);
    logging = 1'b0;
    for (int i = 0; i < ph_n; i++)
      if (ph_hi[i]) chk(ph_w[i] == h, "R4 last high full width", ph_w[i], h);
    for (int i = 0; i < 20; i++) begin
      #3;
      chk(card_clk == 1'b0, "R4 parked low", card_clk, 0);
    end
    log_start();
    run = 1'b1;
    cyc(40);
    logging = 1'b0;
    chk(ph_n >= 2, "R5 output restarted", ph_n, 2);
    for (int i = 0; i < ph_n; i++) begin
      if (ph_hi[i]) chk(ph_w[i] == h, "R5 high full width", ph_w[i], h);
      else          chk(ph_w[i] >= h, "R5 low not short", ph_w[i], h);
    end
  endtask

  initial begin
    #(longint'(CLK_PERIOD) * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_steady(2'b00, "R1 div8");
    t_steady(2'b01, "R1 div4");
    t_steady(2'b11, "R1 div2");
    t_steady(2'b10, "R2 pass-through");
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        if (a != b) t_switch(2'(a), 2'(b));
    t_glitch();
    t_run(2'b01);
    t_run(2'b10);
    t_run(2'b00);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule